// File: doc/BRIEF.md
# GPIO Interrupt Summary Aggregator

This block collapses the pending lines of a large bank of GPIO pins into one interrupt towards the processor. The pins are taken four at a time: each group of four consecutive pins drives one summary bit, so 184 pins yield 46 summary bits. Software reads the summary through two 32-bit words: a low word with summary bits 31:0 and a high word with bits 63:32. Positions above the last real group always read as zero. From these words software finds the groups with pending pins. It then visits those pins and clears each one at its own pin register, which lies outside this block.

The interrupt output is a sticky request. It rises when any summary bit is set. After that it stays high, even if every pin stops pending. The processor takes it with no acknowledge step at this block. After servicing, software sets an end-of-service bit in a control word. That write drops the output for one cycle and re-arms it. If any group is still pending, the output rises again on the next cycle. Reading the status words never changes any state.

The register port is a plain single-cycle port. A two-bit address selects the summary low word, the summary high word, the control word or a spare slot. Writes take effect on the clock edge, and read data is combinational from the selected word.

Top module: `gpio_irq_summary`

## Requirements
- R1: Summary bit n is the OR of pin pending inputs 4n, 4n+1, 4n+2 and 4n+3. It is registered once, so a change on the pins is visible in the read data after the next clock edge.
- R2: Address 0 reads summary bits 31:0. Address 1 reads summary bits 63:32, so group 32+k appears at bit k of that word.
- R3: Summary positions 46 to 63 read as zero. With the default size, bits 31:14 of address 1 are always zero.
- R4: When the output is low and any summary bit is set at a clock edge, the interrupt output goes high after that edge. It is never high unless a summary bit was set in the cycle before it rose.
- R5: Once high, the interrupt output stays high until an end-of-service write, even if every pin stops pending.
- R6: A write to address 2 with bit 29 set is an end-of-service write. It drives the interrupt output low after that edge. On the following edge the output rises again if any summary bit is still set.
- R7: The control word at address 2 always reads zero, so the end-of-service bit clears itself. A write to address 2 with bit 29 clear has no effect on the output. Writes to addresses 0, 1 and 3 change nothing.
- R8: Reads have no side effects. Repeated reads of the status words leave both the summary and the output unchanged.
- R9: While reset is held and after it is released, with no pins pending, the interrupt output is low and every word reads zero.
- R10: Address 3 always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pin_pend | input | 184 | Per-pin pending lines from the pin logic |
| reg_addr | input | 2 | Word select: 0 summary low, 1 summary high, 2 control, 3 spare |
| reg_wr | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with its default size: 184 pins, four pins per group and 46 groups. That size puts the last real group at bit 13 of the high word. It also leaves eighteen unused positions directly above, so the boundary between bit 45 and bit 46 can be exercised with every pin pending. The bench drives single pins in the first, a middle and the last group. It checks the one-edge latency through the summary register and the two-edge drop-and-rise that follows an end-of-service write while groups are still pending.

// File: rtl/gis_pkg.sv
package gis_pkg;
  typedef enum logic [1:0] {
    SEL_SUM_LO = 2'd0,
    SEL_SUM_HI = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_SPARE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gis_grp_reduce.sv
module gis_grp_reduce #(
  parameter int NUM_PINS     = 184,
  parameter int PINS_PER_GRP = 4,
  parameter int NUM_GRPS     = (NUM_PINS + PINS_PER_GRP - 1) / PINS_PER_GRP
) (
  input  logic [NUM_PINS-1:0] pin_pend,
  output logic [NUM_GRPS-1:0] grp_live
);
  localparam int PADDED_W = NUM_GRPS * PINS_PER_GRP;

  logic [PADDED_W-1:0] padded;

  // Pins past the last real one (partial final group) are tied low.
  for (genvar i = 0; i < PADDED_W; i++) begin : g_pad
    if (i < NUM_PINS) begin : g_real
      assign padded[i] = pin_pend[i];
    end else begin : g_fill
      assign padded[i] = 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_GRPS; g++) begin : g_grp
    assign grp_live[g] = |padded[g*PINS_PER_GRP +: PINS_PER_GRP];
  end
endmodule

// File: rtl/gis_sum_view.sv
module gis_sum_view
  import gis_pkg::*;
#(
  parameter int NUM_GRPS = 46,
  parameter int REG_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_GRPS-1:0] grp_live,
  input  logic [1:0]          rd_sel,
  output logic [REG_W-1:0]    rd_data,
  output logic                sum_any
);
  localparam int VIEW_W = 2 * REG_W;

  logic [NUM_GRPS-1:0] sum_q;
  logic [NUM_GRPS-1:0] sum_d;
  logic [VIEW_W-1:0]   view;

  // Next state: the summary is refreshed every cycle.
  always_comb begin
    sum_d = grp_live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else begin
      sum_q <= sum_d;
    end
  end

  always_comb begin
    view = '0;
    view[NUM_GRPS-1:0] = sum_q;
  end

  always_comb begin
    unique case (reg_sel_e'(rd_sel))
      SEL_SUM_LO: rd_data = view[REG_W-1:0];
      SEL_SUM_HI: rd_data = view[VIEW_W-1:REG_W];
      default:    rd_data = '0;
    endcase
  end

  assign sum_any = |sum_q;

  // R3: positions above the last group read zero in the high word.
  if (NUM_GRPS > REG_W) begin : g_hi_chk
    p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel == SEL_SUM_HI) |-> ((rd_data >> (NUM_GRPS - REG_W)) == '0));
  end

  // R1: with no live group in a cycle, the next cycle's summary is empty.
  p_sum_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_live == '0) |=> !sum_any);

  // R7, R10: control and spare words read zero.
  p_ctrl_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel[1] == 1'b1) |-> (rd_data == '0));
endmodule

// File: rtl/gis_irq_ctl.sv
module gis_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic sum_any,
  input  logic eoi_req,
  output logic irq
);
  logic irq_q;
  logic irq_d;
  logic irq_en;

  // Next state: end of service wins; otherwise the request is sticky.
  always_comb begin
    irq_en = eoi_req | (sum_any & ~irq_q);
    irq_d  = eoi_req ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (irq_en) begin
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

  // R5: held until end of service.
  p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !eoi_req) |=> irq);

  // R6: end of service drops the output.
  p_eoi_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_req |=> !irq);

  // R6: re-armed output rises when a group is still pending.
  p_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && sum_any && !eoi_req) |=> irq);
endmodule

// File: rtl/gpio_irq_summary.sv
module gpio_irq_summary
  import gis_pkg::*;
#(
  parameter int NUM_PINS     = 184,
  parameter int PINS_PER_GRP = 4,
  parameter int REG_W        = 32,
  parameter int EOI_BIT      = 29
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_pend,
  input  logic [1:0]          reg_addr,
  input  logic                reg_wr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  output logic                irq_out
);
  localparam int NUM_GRPS = (NUM_PINS + PINS_PER_GRP - 1) / PINS_PER_GRP;

  logic                rst_meta;
  logic                rst_sync;
  logic [NUM_GRPS-1:0] grp_live;
  logic                sum_any;
  logic                eoi_req;

  // Reset asserts asynchronously and releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign eoi_req = reg_wr && (reg_sel_e'(reg_addr) == SEL_CTRL) && reg_wdata[EOI_BIT];

  gis_grp_reduce #(
    .NUM_PINS    (NUM_PINS),
    .PINS_PER_GRP(PINS_PER_GRP),
    .NUM_GRPS    (NUM_GRPS)
  ) u_reduce (
    .pin_pend(pin_pend),
    .grp_live(grp_live)
  );

  gis_sum_view #(
    .NUM_GRPS(NUM_GRPS),
    .REG_W   (REG_W)
  ) u_view (
    .clk     (clk),
    .rst_n   (rst_sync),
    .grp_live(grp_live),
    .rd_sel  (reg_addr),
    .rd_data (reg_rdata),
    .sum_any (sum_any)
  );

  gis_irq_ctl u_irq (
    .clk    (clk),
    .rst_n  (rst_sync),
    .sum_any(sum_any),
    .eoi_req(eoi_req),
    .irq    (irq_out)
  );

  // R4: a rise is always caused by a set summary bit.
  p_rise_cause_r4: assert property (@(posedge clk) disable iff (!rst_sync)
    $rose(irq_out) |-> $past(sum_any));

  // R7: a control write without the end-of-service bit keeps the output.
  p_ctrl_noop_r7: assert property (@(posedge clk) disable iff (!rst_sync)
    (irq_out && reg_wr && !reg_wdata[EOI_BIT]) |=> irq_out);
endmodule

// File: tb/tb_gpio_irq_summary.sv
`timescale 1ns/1ps
module tb_gpio_irq_summary;
  localparam int NP = 184;
  localparam int NG = 46;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP-1:0] pin_pend;
  logic [1:0]    reg_addr;
  logic          reg_wr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic          irq_out;

  int total = 0;
  int bad   = 0;
  bit chk_on = 1'b0;
  bit done   = 1'b0;

  logic [63:0] sum_ref;
  logic        irq_ref;

  always #2.5 clk = ~clk;

  gpio_irq_summary dut (
    .clk(clk), .rst_n(rst_n), .pin_pend(pin_pend), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] groups_of(input logic [NP-1:0] p);
    logic [63:0] r = '0;
    for (int g = 0; g < NG; g++) begin
      r[g] = p[4*g] | p[4*g+1] | p[4*g+2] | p[4*g+3];
    end
    return r;
  endfunction

  // Behavioural reference, advanced on each clock edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_ref <= '0;
      irq_ref <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == 2'd2 && reg_wdata[29]) irq_ref <= 1'b0;
      else irq_ref <= irq_ref | (sum_ref != 0);
      sum_ref <= groups_of(pin_pend);
    end
  end

  // Compare on every falling edge.
  always @(negedge clk) begin
    if (chk_on) begin
      chk("R4 irq vs model", {31'b0, irq_out}, {31'b0, irq_ref});
      case (reg_addr)
        2'd0: chk("R2 lo vs model", reg_rdata, sum_ref[31:0]);
        2'd1: chk("R2 hi vs model", reg_rdata, sum_ref[63:32]);
        default: chk("R10 spare/ctrl vs model", reg_rdata, 32'h0);
      endcase
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [1:0] a);
    reg_addr = a;
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin_pend = '0; reg_addr = 2'd0; reg_wr = 1'b0; reg_wdata = '0;
    repeat (3) tick();
    chk("R9 irq in reset", {31'b0, irq_out}, 32'h0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R9 irq after reset", {31'b0, irq_out}, 32'h0);
    rd(2'd0); chk("R9 lo after reset", reg_rdata, 32'h0);
    rd(2'd1); chk("R9 hi after reset", reg_rdata, 32'h0);
    chk_on = 1'b1;

    // R1 / R4: pin 5 -> group 1.
    rd(2'd0);
    pin_pend[5] = 1'b1;
    tick();
    rd(2'd0);
    chk("R1 pin5 group1", reg_rdata, 32'h0000_0002);
    chk("R4 not yet high", {31'b0, irq_out}, 32'h0);
    tick();
    chk("R4 high after summary", {31'b0, irq_out}, 32'h1);

    // R5: pins stop pending, output held.
    pin_pend = '0;
    repeat (4) tick();
    chk("R5 held", {31'b0, irq_out}, 32'h1);
    rd(2'd0); chk("R1 cleared", reg_rdata, 32'h0);

    // R6: end of service with nothing pending.
    wr(2'd2, 32'h2000_0000);
    chk("R6 drop", {31'b0, irq_out}, 32'h0);
    repeat (3) tick();
    chk("R6 stays low", {31'b0, irq_out}, 32'h0);
    chk("R7 ctrl reads zero", reg_rdata, 32'h0);

    // R2: last pin -> group 45 -> high word bit 13; first pin -> bit 0.
    pin_pend[183] = 1'b1; pin_pend[0] = 1'b1;
    tick();
    rd(2'd1); chk("R2 hi bit13", reg_rdata, 32'h0000_2000);
    rd(2'd0); chk("R2 lo bit0", reg_rdata, 32'h0000_0001);
    tick();
    chk("R4 high again", {31'b0, irq_out}, 32'h1);

    // R6: end of service with groups pending -> drop then rise.
    wr(2'd2, 32'h2000_0000);
    chk("R6 drop pending", {31'b0, irq_out}, 32'h0);
    tick();
    chk("R6 re-rise", {31'b0, irq_out}, 32'h1);

    // R7: control write without bit 29, status writes.
    wr(2'd2, 32'hDFFF_FFFF);
    chk("R7 no-op ctrl", {31'b0, irq_out}, 32'h1);
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd1); chk("R7 hi unchanged", reg_rdata, 32'h0000_2000);
    rd(2'd0); chk("R7 lo unchanged", reg_rdata, 32'h0000_0001);
    chk("R7 irq unchanged", {31'b0, irq_out}, 32'h1);

    // R3: every pin pending.
    pin_pend = '1;
    tick();
    rd(2'd1); chk("R3 hi upper zero", reg_rdata, 32'h0000_3FFF);
    rd(2'd0); chk("R3 lo all", reg_rdata, 32'hFFFF_FFFF);

    // R8: repeated reads change nothing.
    pin_pend = '0; pin_pend[100] = 1'b1;
    tick();
    for (int k = 0; k < 6; k++) begin
      rd(2'(k % 2));
      tick();
    end
    rd(2'd0); chk("R8 lo stable", reg_rdata, 32'h0200_0000);
    rd(2'd1); chk("R8 hi stable", reg_rdata, 32'h0);
    chk("R8 irq stable", {31'b0, irq_out}, 32'h1);

    // R10: spare address.
    rd(2'd3); chk("R10 spare zero", reg_rdata, 32'h0);

    pin_pend = '0;
    wr(2'd2, 32'h2000_0000);
    repeat (3) tick();
    chk("R6 final low", {31'b0, irq_out}, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule